// File: doc/BRIEF.md
# Write Completion Status Reporter

This block is the read datapath of a byte-wide non-volatile memory model that has a self-timed internal programming cycle. It watches the active-low chip and output enables, the read address, the word the array returns for that address, a busy flag from the write controller, and the address and data of the last byte written. From these it drives the data bus and its drive enable. Array storage and write sequencing are handled elsewhere.

When no programming cycle is running, a read returns array contents. While the device is busy, a read returns a status byte instead. The top bit of the status byte is a data-polling flag: it carries the inverse of the last written byte's top bit when the last written location is read. The next bit down is a toggle flag that changes value once for each new read access. The remaining low bits are reserved and read as zero. Software can poll either flag to tell when the write has finished. A write that was blocked by protection never raises busy, so no status indication is produced for it.

All inputs are sampled on the rising clock edge. The bus and its enable are registered, so they reflect the inputs of the previous edge.

Top module: `wr_status_rdpath`

## Requirements
- R1: While rst_ni is low, bus_oe_o is 0, bus_o is 0, and the toggle flag state is cleared, so that the first busy read after reset shows bit 6 = 1.
- R2: One cycle after an edge at which ce_ni and oe_ni are both low, bus_oe_o is 1. After any edge at which either of them is high, bus_oe_o is 0 and bus_o is all zeros.
- R3: During a read with busy_i low at the sampling edge, bus_o equals the arr_data_i value sampled at that edge.
- R4: During a read with busy_i high and rd_addr_i equal to last_addr_i, bus_o bit 7 is the inverse of last_data_i bit 7.
- R5: During a read with busy_i high and rd_addr_i different from last_addr_i, bus_o bit 7 is 0.
- R6: During a read with busy_i high, bus_o bits 5 down to 0 are 0.
- R7: Bus bit 6 inverts at the first edge of each new read access (strobe low after being high) when busy_i is high at that edge. It is the toggle state after that update.
- R8: Within one continuing access, bit 6 keeps its value from cycle to cycle while busy_i stays high.
- R9: Read accesses with busy_i low do not advance the toggle state. The next busy access continues from the held value.
- R10: If busy_i falls during an ongoing access, the next cycle returns array data. If busy_i rises during an ongoing access, the status byte shows the current toggle state without advancing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| rd_addr_i | input | ADDR_W | Read address |
| arr_data_i | input | DATA_W | Array word at rd_addr_i |
| busy_i | input | 1 | Internal programming cycle in progress |
| last_addr_i | input | ADDR_W | Address of the last byte written |
| last_data_i | input | DATA_W | Value of the last byte written |
| bus_o | output | DATA_W | Data driven onto the bus (zero when not driving) |
| bus_oe_o | output | 1 | Bus drive enable; low means high impedance |

## Verification
The start of a read access can land on the same edge as a change of busy_i. The bench provokes this in two ways. In one case, busy_i rises on the very edge where the strobe first goes low, which must both advance the toggle and show status. In the other case, busy_i rises or falls during an access that is already open, which must switch the source without advancing the toggle. Each cycle's expected byte comes from a reference model kept in the bench, built from the requirements and queued by the driver. The model's value is compared against the registered bus output after the edge.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  typedef enum logic [1:0] {
    SRC_OFF    = 2'd0,
    SRC_ARRAY  = 2'd1,
    SRC_STATUS = 2'd2
  } rd_src_e;
endpackage

// File: rtl/wcs_strobe.sv
module wcs_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  output logic act_o,
  output logic start_o
);
  logic act_q;

  assign act_o   = ~ce_ni & ~oe_ni;
  assign start_o = act_o & ~act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act_o;
  end
endmodule

// File: rtl/wcs_toggle.sv
module wcs_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output logic tog_nxt_o
);
  logic tog_q;

  // value after this edge's update, so a fresh access shows the new state
  assign tog_nxt_o = adv_i ? ~tog_q : tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else         tog_q <= tog_nxt_o;
  end
endmodule

// File: rtl/wcs_mux.sv
module wcs_mux
  import wcs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              act_i,
  input  logic              busy_i,
  input  logic              match_i,
  input  logic              last_msb_i,
  input  logic              tog_i,
  input  logic [DATA_W-1:0] arr_i,
  output rd_src_e           src_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  logic [DATA_W-1:0] status;

  always_comb begin
    if (!act_i)      src_o = SRC_OFF;
    else if (busy_i) src_o = SRC_STATUS;
    else             src_o = SRC_ARRAY;
  end

  always_comb begin
    status           = '0;
    status[POLL_BIT] = match_i & ~last_msb_i;
    status[TOG_BIT]  = tog_i;
  end

  always_comb begin
    unique case (src_o)
      SRC_ARRAY:  data_o = arr_i;
      SRC_STATUS: data_o = status;
      default:    data_o = '0;
    endcase
  end
endmodule

// File: rtl/wr_status_rdpath.sv
module wr_status_rdpath
  import wcs_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] arr_data_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] last_addr_i,
  input  logic [DATA_W-1:0] last_data_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o
);
  logic              rd_act, rd_start, tog_nxt, addr_hit;
  rd_src_e           src;
  logic [DATA_W-1:0] bus_d;

  wcs_strobe u_strobe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ce_ni   (ce_ni),
    .oe_ni   (oe_ni),
    .act_o   (rd_act),
    .start_o (rd_start)
  );

  // toggle advances once per access, only while programming
  wcs_toggle u_toggle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (rd_start & busy_i),
    .tog_nxt_o (tog_nxt)
  );

  assign addr_hit = (rd_addr_i == last_addr_i);

  wcs_mux #(.DATA_W(DATA_W)) u_mux (
    .act_i      (rd_act),
    .busy_i     (busy_i),
    .match_i    (addr_hit),
    .last_msb_i (last_data_i[DATA_W-1]),
    .tog_i      (tog_nxt),
    .arr_i      (arr_data_i),
    .src_o      (src),
    .data_o     (bus_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_o    <= '0;
      bus_oe_o <= 1'b0;
    end else begin
      bus_o    <= bus_d;
      bus_oe_o <= (src != SRC_OFF);
    end
  end
endmodule

// File: rtl/wr_status_rdpath_chk.sv
module wr_status_rdpath_chk #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [DATA_W-1:0] arr_data_i,
  input logic              busy_i,
  input logic [ADDR_W-1:0] last_addr_i,
  input logic [DATA_W-1:0] last_data_i,
  input logic [DATA_W-1:0] bus_o,
  input logic              bus_oe_o
);
  logic rd_on;
  assign rd_on = ~ce_ni & ~oe_ni;

  // R1
  always_comb begin
    if (!rst_ni) begin
      rst_quiet_chk: assert (!bus_oe_o && bus_o == '0);
    end
  end

  // R2
  oe_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_on |=> bus_oe_o);

  // R2
  oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_on |=> (!bus_oe_o && bus_o == '0));

  // R3
  array_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_on && !busy_i) |=> bus_o == $past(arr_data_i));

  // R4
  poll_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_on && busy_i && rd_addr_i == last_addr_i)
      |=> bus_o[DATA_W-1] == ~$past(last_data_i[DATA_W-1]));

  // R5
  poll_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_on && busy_i && rd_addr_i != last_addr_i) |=> !bus_o[DATA_W-1]);

  // R6
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_on && busy_i) |=> bus_o[DATA_W-3:0] == '0);

  // R8
  tog_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_on && busy_i && bus_oe_o && $past(busy_i)) |=> $stable(bus_o[DATA_W-2]));
endmodule

bind wr_status_rdpath wr_status_rdpath_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ce_ni       (ce_ni),
  .oe_ni       (oe_ni),
  .rd_addr_i   (rd_addr_i),
  .arr_data_i  (arr_data_i),
  .busy_i      (busy_i),
  .last_addr_i (last_addr_i),
  .last_data_i (last_data_i),
  .bus_o       (bus_o),
  .bus_oe_o    (bus_oe_o)
);

// File: tb/wr_status_rdpath_bench.sv
module wr_status_rdpath_bench;
  localparam int AW = 13;
  localparam int DW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ce_ni = 1'b1, oe_ni = 1'b1, busy_i = 1'b0;
  logic [AW-1:0] rd_addr_i = '0, last_addr_i = '0;
  logic [DW-1:0] arr_data_i = '0, last_data_i = '0;
  logic [DW-1:0] bus_o;
  logic          bus_oe_o;

  int total = 0, bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic          oe;
    logic [DW-1:0] bus;
    string         tag;
  } exp_t;
  exp_t q[$];

  // reference state built from the requirements
  bit m_prev_act = 1'b0;
  bit m_tog = 1'b0;

  always #5 clk_i = ~clk_i;

  wr_status_rdpath #(.ADDR_W(AW), .DATA_W(DW)) u_wr_status_rdpath (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .oe_ni(oe_ni),
    .rd_addr_i(rd_addr_i), .arr_data_i(arr_data_i), .busy_i(busy_i),
    .last_addr_i(last_addr_i), .last_data_i(last_data_i),
    .bus_o(bus_o), .bus_oe_o(bus_oe_o)
  );

  task automatic step(input bit ce, input bit oe, input logic [AW-1:0] a,
                      input logic [DW-1:0] arr, input bit bsy,
                      input logic [AW-1:0] la, input logic [DW-1:0] ld,
                      input string tag);
    exp_t e;
    bit act;
    @(negedge clk_i);
    ce_ni = ce; oe_ni = oe; rd_addr_i = a; arr_data_i = arr;
    busy_i = bsy; last_addr_i = la; last_data_i = ld;
    act = !ce && !oe;
    if (act && !m_prev_act && bsy) m_tog = ~m_tog;
    m_prev_act = act;
    e.oe  = act;
    e.tag = tag;
    if (!act)     e.bus = '0;
    else if (bsy) e.bus = {(a == la) ? ~ld[DW-1] : 1'b0, m_tog, 6'b0};
    else          e.bus = arr;
    q.push_back(e);
  endtask

  // monitor: compare after each edge
  always @(posedge clk_i) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (bus_oe_o !== e.oe || bus_o !== e.bus) begin
        bad++;
        $display("FAIL %s: got oe=%0b bus=%02h exp oe=%0b bus=%02h",
                 e.tag, bus_oe_o, bus_o, e.oe, e.bus);
      end
    end
  end

  initial begin
    #(20000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang exp finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2;
    total++;
    if (bus_oe_o !== 1'b0 || bus_o !== '0) begin
      bad++;
      $display("FAIL R1 reset: got oe=%0b bus=%02h exp oe=0 bus=00", bus_oe_o, bus_o);
    end
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    step(0, 0, 13'h0100, 8'h3C, 0, 13'h0100, 8'h11, "R2 R3 idle read");
    step(1, 0, 13'h0100, 8'h3C, 0, 13'h0100, 8'h11, "R2 ce high");
    step(0, 1, 13'h0100, 8'h3C, 0, 13'h0100, 8'h11, "R2 oe high");
    // read start on the same edge busy rises
    step(0, 0, 13'h0555, 8'hFF, 1, 13'h0555, 8'h5A, "R1 R4 R6 R7 first busy read");
    step(0, 0, 13'h0555, 8'hFF, 1, 13'h0555, 8'h5A, "R8 hold in access");
    step(1, 1, 13'h0555, 8'hFF, 1, 13'h0555, 8'h5A, "R2 release");
    step(0, 0, 13'h0555, 8'h00, 1, 13'h0555, 8'hA5, "R4 R7 second busy read");
    step(1, 1, 13'h0555, 8'h00, 1, 13'h0555, 8'hA5, "R2 release");
    step(0, 0, 13'h0AAA, 8'h77, 1, 13'h0555, 8'h5A, "R5 R6 R7 miss address");
    step(0, 0, 13'h0AAA, 8'h77, 0, 13'h0555, 8'h5A, "R10 busy falls mid access");
    step(1, 1, 13'h0AAA, 8'h77, 0, 13'h0555, 8'h5A, "R2 release");
    step(0, 0, 13'h0012, 8'h9E, 0, 13'h0555, 8'h5A, "R3 R9 idle read a");
    step(1, 0, 13'h0012, 8'h9E, 0, 13'h0555, 8'h5A, "R2 release");
    step(0, 0, 13'h0013, 8'h81, 0, 13'h0555, 8'h5A, "R3 R9 idle read b");
    // busy rises inside an open access: no advance
    step(0, 0, 13'h0013, 8'h81, 1, 13'h0013, 8'h02, "R10 busy rises mid access");
    step(1, 1, 13'h0013, 8'h81, 1, 13'h0013, 8'h02, "R2 release");
    step(0, 0, 13'h0013, 8'h81, 1, 13'h0013, 8'h02, "R7 R9 resumed toggle");
    step(0, 0, 13'h0013, 8'h81, 1, 13'h0013, 8'h02, "R8 hold again");
    step(1, 1, 13'h0013, 8'h81, 0, 13'h0013, 8'h02, "R2 release");
    step(0, 0, 13'h0013, 8'h81, 0, 13'h0013, 8'h02, "R3 done true data");

    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule